// File: doc/BRIEF.md
# Divided-Wordline 4x4 Static Memory Array

This block is a synthesizable behavioural model of a small static memory organised as four rows of four single-bit cells. A one-hot row decoder drives a global wordline per row and a one-hot column decoder drives a dataline per column. Each cell has its own local wordline, which rises only when both its row and its column are selected. Each access therefore opens exactly one cell and leaves the other fifteen untouched.

Every access needs a precharge phase first. The precharge control is active low. While it is low, both bitlines of every column sit at logic 1 and no access may take place. Once a cell has been accessed, the block accepts no further request until another precharge phase has been seen. A standby input puts the array into retention: requests are refused and the stored bits are kept. The model exposes the local wordlines and the bitline pair of each column so that the array's activity can be observed. A read places the selected bit on its column's output bit one clock later.

An access is accepted in a cycle when the request is high, precharge is released, standby is low, and a precharge phase has occurred since the last accepted access.

Top module: `dwl_sram_array`

## Requirements
- R1: A synchronous active-low reset clears all 16 cells and all data-out bits to 0, deasserts every local wordline, and leaves the array primed, as if a precharge phase had just occurred.
- R2: During an accepted access to row r and column c, local wordline bit r*4+c is the only one asserted. When no access is accepted, all local wordlines are low.
- R3: An accepted access with write enable high stores the data-in bit into the addressed cell. The value is visible to any later read.
- R4: An accepted access with write enable low copies the addressed cell into data-out bit c at the next clock edge. The other data-out bits keep their values.
- R5: In every cycle at most one local wordline is high.
- R6: While the active-low precharge control is low, both bitlines of every column read 1 and any request is ignored.
- R7: While standby is high, requests are ignored, the local wordlines stay low, and stored contents do not change.
- R8: After an accepted access, further requests are ignored until a cycle with precharge low has occurred.
- R9: During an accepted access, the selected column's true bitline carries the bit being read or written and its complement carries the inverse. Unselected columns keep both bitlines at 1.
- R10: Data out holds its value in every cycle without an accepted read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 1 | Access request for this cycle |
| row_addr | input | 2 | Row (word) select |
| col_addr | input | 2 | Column (bit) select |
| wr_en | input | 1 | 1 = write, 0 = read |
| pchg_n | input | 1 | Precharge control, low = precharging |
| standby | input | 1 | Retention mode when high |
| din | input | 1 | Bit to write |
| dout | output | 4 | Read data, one bit per column, registered |
| lwl | output | 16 | Local wordlines, index row*4+col |
| bl | output | 4 | True bitline per column |
| blb | output | 4 | Complement bitline per column |

## Verification
The local wordlines and the bitlines respond to the current cycle's inputs. The bench therefore drives its inputs just after the falling edge and checks these outputs one nanosecond later, before the next rising edge. Read data, stored contents and the priming flag change at the rising edge that ends the access cycle. For that reason, the bench updates its behavioural model at that edge and compares data out one nanosecond after it. On every cycle it checks the wordlines, the bitlines and data out against the model. Directed phases then read cells back through the normal access protocol, so that writes, ignored requests and reset contents can be seen at the ports.

// File: rtl/dwl_pkg.sv
`timescale 1ns/1ps
// Shared types for the divided-wordline array.
package dwl_pkg;
    // Kind of access granted in the current cycle.
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_t;
endpackage

// File: rtl/dwl_onehot_dec.sv
`timescale 1ns/1ps
// One-hot decoder: drives exactly one of N lines while enabled, none otherwise.
// Assumes N <= 2**W.
module dwl_onehot_dec #(
    parameter int N = 4,
    parameter int W = 2
) (
    input  logic         en,
    input  logic [W-1:0] sel,
    output logic [N-1:0] line
);
    // One comparator per output line.
    for (genvar i = 0; i < N; i++) begin : g_line
        assign line[i] = en && (sel == W'(i));
    end
endmodule

// File: rtl/dwl_access_ctrl.sv
`timescale 1ns/1ps
// Access gate: grants a read or write only when precharge is released, standby is
// low and a precharge phase has been seen since the previous granted access.
// Assumes the inputs are synchronous to clk.
module dwl_access_ctrl
    import dwl_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req,
    input  logic      wr_en,
    input  logic      pchg_n,
    input  logic      standby,
    output acc_kind_t kind
);
    logic primed;

    // Grant decision for the present cycle.
    always_comb begin
        kind = ACC_IDLE;
        if (rst_n && req && pchg_n && !standby && primed)
            kind = wr_en ? ACC_WRITE : ACC_READ;
    end

    // Priming flag: set by a precharge phase, consumed by a granted access.
    always_ff @(posedge clk) begin
        if (!rst_n)
            primed <= 1'b1;
        else if (!pchg_n)
            primed <= 1'b1;
        else if (kind != ACC_IDLE)
            primed <= 1'b0;
    end

    // Two granted accesses in a row are impossible without a precharge between.
    assert_prime_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (kind != ACC_IDLE) |=> (kind == ACC_IDLE));
endmodule

// File: rtl/dwl_cell_array.sv
`timescale 1ns/1ps
// Cell matrix with per-cell local wordlines formed from row wordline AND column
// dataline. Only the cell whose local wordline is high is read or written.
// Assumes at most one row wordline and one dataline are high at a time.
module dwl_cell_array #(
    parameter int ROWS = 4,
    parameter int COLS = 4,
    localparam int CELLS = ROWS * COLS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ROWS-1:0]  rwl,
    input  logic [COLS-1:0]  dl,
    input  logic             wr,
    input  logic             din,
    output logic [CELLS-1:0] lwl,
    output logic [COLS-1:0]  col_val
);
    logic [CELLS-1:0] cells;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            localparam int IDX = r * COLS + c;
            // Local wordline gate for this cell.
            assign lwl[IDX] = rwl[r] & dl[c];
            // Storage bit: cleared by reset, written only when opened for a write.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    cells[IDX] <= 1'b0;
                else if (lwl[IDX] && wr)
                    cells[IDX] <= din;
            end
        end
    end

    // Column sense: the opened cell of each column drives its value.
    always_comb begin
        col_val = '0;
        for (int c = 0; c < COLS; c++)
            for (int r = 0; r < ROWS; r++)
                col_val[c] = col_val[c] | (lwl[r*COLS+c] & cells[r*COLS+c]);
    end

    assert_one_lwl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lwl));
    assert_cell_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lwl == '0) |=> $stable(cells));
endmodule

// File: rtl/dwl_sram_array.sv
`timescale 1ns/1ps
// Divided-wordline static memory: row and column decoders, gated local
// wordlines, bitline pair per column and a registered read-out bit per column.
// Assumes synchronous inputs; the precharge control is active low.
module dwl_sram_array
    import dwl_pkg::*;
#(
    parameter int ROWS = 4,
    parameter int COLS = 4,
    localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int CW = (COLS > 1) ? $clog2(COLS) : 1,
    localparam int CELLS = ROWS * COLS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [RW-1:0]    row_addr,
    input  logic [CW-1:0]    col_addr,
    input  logic             wr_en,
    input  logic             pchg_n,
    input  logic             standby,
    input  logic             din,
    output logic [COLS-1:0]  dout,
    output logic [CELLS-1:0] lwl,
    output logic [COLS-1:0]  bl,
    output logic [COLS-1:0]  blb
);
    acc_kind_t       kind;
    logic            active;
    logic [ROWS-1:0] rwl;
    logic [COLS-1:0] dl;
    logic [COLS-1:0] col_val;

    dwl_access_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .req(req), .wr_en(wr_en),
        .pchg_n(pchg_n), .standby(standby), .kind(kind)
    );

    assign active = (kind != ACC_IDLE);

    dwl_onehot_dec #(.N(ROWS), .W(RW)) u_row_dec (
        .en(active), .sel(row_addr), .line(rwl)
    );
    dwl_onehot_dec #(.N(COLS), .W(CW)) u_col_dec (
        .en(active), .sel(col_addr), .line(dl)
    );

    dwl_cell_array #(.ROWS(ROWS), .COLS(COLS)) u_arr (
        .clk(clk), .rst_n(rst_n), .rwl(rwl), .dl(dl),
        .wr(kind == ACC_WRITE), .din(din), .lwl(lwl), .col_val(col_val)
    );

    // Bitline pair per column: precharged high, split only on the opened column.
    always_comb begin
        for (int c = 0; c < COLS; c++) begin
            bl[c]  = 1'b1;
            blb[c] = 1'b1;
            if (pchg_n && dl[c]) begin
                bl[c]  = (kind == ACC_WRITE) ? din : col_val[c];
                blb[c] = ~bl[c];
            end
        end
    end

    // Read-out register: the selected column captures its cell on a read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dout <= '0;
        else
            for (int c = 0; c < COLS; c++)
                if (kind == ACC_READ && dl[c])
                    dout[c] <= col_val[c];
    end

    assert_pchg_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !pchg_n |-> ((&bl) && (&blb)));
    assert_bl_split_R9: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> ($countones(bl ^ blb) == 1));
    assert_standby_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        standby |-> (lwl == '0));
    assert_dout_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (kind != ACC_READ) |=> $stable(dout));
    assert_lwl_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> lwl[row_addr*COLS + col_addr]);
endmodule

// File: tb/sim_dwl_sram_array.sv
`timescale 1ns/1ps
// Self-checking bench with a behavioural reference model compared every cycle.
module sim_dwl_sram_array;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [1:0]  row_addr = '0;
    logic [1:0]  col_addr = '0;
    logic        wr_en = 1'b0;
    logic        pchg_n = 1'b0;
    logic        standby = 1'b0;
    logic        din = 1'b0;
    logic [3:0]  dout;
    logic [15:0] lwl;
    logic [3:0]  bl;
    logic [3:0]  blb;

    int total = 0;
    int bad = 0;

    bit   m_mem [16];
    bit   m_primed;
    logic [3:0]  m_dout;
    logic [15:0] obs_lwl;

    always #2.5 clk = ~clk;

    dwl_sram_array u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .row_addr(row_addr),
        .col_addr(col_addr), .wr_en(wr_en), .pchg_n(pchg_n),
        .standby(standby), .din(din), .dout(dout), .lwl(lwl),
        .bl(bl), .blb(blb)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // One clock of stimulus with per-cycle comparison against the model.
    task automatic step(input bit rq, input int r, input int c, input bit we,
                        input bit pn, input bit sb, input bit d);
        bit acc;
        logic [15:0] e_lwl;
        logic [3:0] e_bl, e_blb;
        @(negedge clk);
        req = rq; row_addr = 2'(r); col_addr = 2'(c); wr_en = we;
        pchg_n = pn; standby = sb; din = d;
        #1;
        acc = rq && pn && !sb && m_primed;
        e_lwl = acc ? (16'd1 << (r*4 + c)) : 16'd0;
        e_bl = 4'hF; e_blb = 4'hF;
        if (acc) begin
            e_bl[c]  = we ? d : m_mem[r*4 + c];
            e_blb[c] = ~e_bl[c];
        end
        obs_lwl = lwl;
        chk(lwl == e_lwl, "R2", 32'(lwl), 32'(e_lwl));
        chk($countones(lwl) <= 1, "R5", 32'($countones(lwl)), 32'd1);
        chk({bl, blb} == {e_bl, e_blb}, pn ? "R9" : "R6",
            32'({bl, blb}), 32'({e_bl, e_blb}));
        @(posedge clk);
        if (!pn) m_primed = 1'b1;
        else if (acc) m_primed = 1'b0;
        if (acc && we) m_mem[r*4 + c] = d;
        if (acc && !we) m_dout[c] = m_mem[r*4 + c];
        #1;
        chk(dout == m_dout, (acc && !we) ? "R4" : "R10", 32'(dout), 32'(m_dout));
    endtask

    task automatic pre();
        step(1'b0, 0, 0, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic wr_cell(input int r, input int c, input bit d);
        pre();
        step(1'b1, r, c, 1'b1, 1'b1, 1'b0, d);
    endtask

    task automatic rd_cell(input int r, input int c);
        pre();
        step(1'b1, r, c, 1'b0, 1'b1, 1'b0, 1'b0);
    endtask

    initial begin
        #(5.0 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog act=0 exp=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) m_mem[i] = 1'b0;
        m_primed = 1'b1;
        m_dout = 4'h0;
        repeat (3) @(posedge clk);
        #1;
        chk(dout == 4'h0, "R1", 32'(dout), 32'h0);
        chk(lwl == 16'h0, "R1", 32'(lwl), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: first access needs no extra precharge; every cell reads 0.
        step(1'b1, 3, 3, 1'b0, 1'b1, 1'b0, 1'b0);
        chk(obs_lwl == 16'h8000, "R1", 32'(obs_lwl), 32'h8000);
        for (int i = 0; i < 16; i++) begin
            rd_cell(i / 4, i % 4);
            chk(dout[i % 4] == 1'b0, "R1", 32'(dout[i % 4]), 32'h0);
        end
        // R3: write a pattern, read it back.
        for (int i = 0; i < 16; i++) wr_cell(i / 4, i % 4, 1'((i * 5 + 1) % 3 == 0));
        for (int i = 0; i < 16; i++) begin
            rd_cell(i / 4, i % 4);
            chk(dout[i % 4] == 1'((i * 5 + 1) % 3 == 0), "R3",
                32'(dout[i % 4]), 32'((i * 5 + 1) % 3 == 0));
        end
        // R7: standby blocks a write and keeps the stored bit.
        wr_cell(1, 2, 1'b1);
        pre();
        step(1'b1, 1, 2, 1'b1, 1'b1, 1'b1, 1'b0);
        chk(obs_lwl == 16'h0, "R7", 32'(obs_lwl), 32'h0);
        step(1'b0, 1, 2, 1'b0, 1'b1, 1'b0, 1'b0);
        rd_cell(1, 2);
        chk(dout[2] == 1'b1, "R7", 32'(dout[2]), 32'h1);
        // R6: a request during precharge is ignored.
        step(1'b1, 1, 2, 1'b1, 1'b0, 1'b0, 1'b0);
        chk(obs_lwl == 16'h0, "R6", 32'(obs_lwl), 32'h0);
        rd_cell(1, 2);
        chk(dout[2] == 1'b1, "R6", 32'(dout[2]), 32'h1);
        // R8: a second write without precharge between is refused.
        wr_cell(2, 3, 1'b1);
        step(1'b1, 2, 3, 1'b1, 1'b1, 1'b0, 1'b0);
        chk(obs_lwl == 16'h0, "R8", 32'(obs_lwl), 32'h0);
        rd_cell(2, 3);
        chk(dout[3] == 1'b1, "R8", 32'(dout[3]), 32'h1);
        // Random traffic, then a full read-back sweep.
        for (int n = 0; n < 3000; n++) begin
            int k;
            k = int'($urandom_range(0, 9));
            step(k != 0, int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
                 1'($urandom_range(0, 1)), k > 3, k == 1, 1'($urandom_range(0, 1)));
        end
        for (int i = 0; i < 16; i++) begin
            rd_cell(i / 4, i % 4);
            chk(dout[i % 4] == m_mem[i], "R3", 32'(dout[i % 4]), 32'(m_mem[i]));
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule